// File: doc/BRIEF.md
# TPM SPI Flow-Controlled Register Target

This block is the device side of a SPI link that carries TPM register accesses. The host opens each transaction by pulling chip select low. It then sends a four-byte header that gives the direction, the payload length and a 24-bit register address. The block decodes the header and then holds the host off with wait bytes. It keeps doing so for as long as the internal logic behind its register port reports that it is not ready. It then returns a single ready byte, and payload bytes move from the byte after that one. Each payload byte becomes one strobe on a simple byte-wide register port, toward a register file or command engine that lives elsewhere.

When a transaction has run to completion and chip select is released, the block drives an active-low ready pulse. This tells the host that the next transaction may start. The pulse has a short default length. A configuration bit, written through the same SPI path, stretches it to a long length. All SPI inputs are resynchronised into the system clock domain, so the system clock must run several times faster than SCLK.

The controlling FSM has six states:
- IDLE: waits for chip select to fall, which moves it to HDR.
- HDR: collects the header. When the fourth byte ends it moves to RDY if `reg_ready` is high, and to WAIT otherwise.
- WAIT: returns 0x00 bytes. It moves to RDY at the first byte boundary where `reg_ready` is high.
- RDY: returns 0x01 and moves to DATA when that byte ends.
- DATA: moves one payload byte per SPI byte and moves to DONE after the last one.
- DONE: returns 0x00 until chip select rises.

A chip-select rise in any state returns the FSM to IDLE. The ready pulse fires only when that rise happens in DONE.

Top module: `tpm_spi_target`

## Requirements
- R1: Out of reset, `irq_rdy_n` is high, `spi_miso` is low, and neither `reg_rd` nor `reg_wr` is asserted.
- R2: SPI is mode 0, and every byte travels MSB first. In header byte 0, bit 7 set means read and clear means write, and bits 5:0 hold the payload length minus one. Header bytes 1 to 3 hold the register address, most significant byte first.
- R3: The target returns 0x00 during all four header bytes. After the header it returns one 0x00 wait byte for each byte boundary at which `reg_ready` is low.
- R4: At the first byte boundary from the end of the header onward at which `reg_ready` is high, the next byte returned is exactly 0x01. The payload starts on the byte after it.
- R5: A read issues one `reg_rd` strobe per payload byte, with `reg_addr` starting at the header address and rising by one for each byte. Each payload byte returned equals the `reg_rdata` present during its strobe.
- R6: A write returns 0x00 on MISO during the payload. It issues one `reg_wr` strobe per payload byte, with the received byte on `reg_wdata` and `reg_addr` starting at the header address and rising by one for each byte.
- R7: When chip select rises after a complete transaction, `irq_rdy_n` goes low for exactly SHORT_CYC clock cycles while long mode is off.
- R8: A written byte whose address has low 12 bits of 0xFE0 sets long mode from its bit 1. In long mode the ready pulse lasts exactly LONG_CYC cycles. A write to any other address leaves the mode unchanged.
- R9: If chip select rises before the payload is complete, the transaction is dropped without a ready pulse and without any further strobe. The next transaction is decoded from a fresh header.
- R10: Bytes clocked after the last payload byte return 0x00 and cause no register strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than SCLK |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | SPI serial clock from the host |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Host-to-target serial data |
| spi_miso | output | 1 | Target-to-host serial data |
| irq_rdy_n | output | 1 | Active-low ready pulse after each completed transaction |
| reg_ready | input | 1 | Internal logic can take the access now |
| reg_rd | output | 1 | One-cycle read strobe |
| reg_wr | output | 1 | One-cycle write strobe |
| reg_addr | output | ADDR_W | Address of the current strobe |
| reg_wdata | output | 8 | Write data, valid with `reg_wr` |
| reg_rdata | input | 8 | Read data, sampled in the cycle of `reg_rd` |

## Verification
The SPI inputs pass through a two-stage synchroniser and one edge-detect flop. As a result, each MISO byte is decided about three system clocks after the eighth rising SCLK edge of the previous byte. The bench samples MISO only at its own next rising SCLK edge, at least nine clocks later, so the byte is always settled by then. The ready pulse starts three clocks after chip select rises. The bench therefore does not pin down its start cycle: it measures each low stretch on every falling clock edge and compares its exact length against SHORT_CYC or LONG_CYC. Register strobes are logged on falling edges, then compared with the addresses and data the reference model expects once chip select has been released.

// File: rtl/tpm_spi_pkg.sv
package tpm_spi_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HDR,
        ST_WAIT,
        ST_RDY,
        ST_DATA,
        ST_DONE
    } tgt_state_e;

    localparam int HDR_BYTES  = 4;
    localparam logic [7:0] WAIT_BYTE = 8'h00;
    localparam logic [7:0] GO_BYTE   = 8'h01;
endpackage

// File: rtl/spi_byte_port.sv
module spi_byte_port #(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sclk,
    input  logic       cs_n,
    input  logic       mosi,
    input  logic       tx_load,
    input  logic [7:0] tx_byte,
    output logic       miso,
    output logic       cs_act,
    output logic       cs_fall,
    output logic       cs_rise,
    output logic       byte_done,
    output logic [7:0] rx_byte
);
    localparam int TOP = SYNC_STAGES - 1;

    logic [TOP:0] sclk_sy, cs_sy, mosi_sy;
    logic         sclk_d, cs_d;
    logic         sclk_s, cs_s, mosi_s;
    logic         sclk_rise, sclk_fall;
    logic [2:0]   bit_cnt;
    logic [6:0]   rx_sr;
    logic [7:0]   tx_sr;

    generate
        for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    sclk_sy[i] <= 1'b0;
                    cs_sy[i]   <= 1'b1;
                    mosi_sy[i] <= 1'b0;
                end else if (i == 0) begin
                    sclk_sy[i] <= sclk;
                    cs_sy[i]   <= cs_n;
                    mosi_sy[i] <= mosi;
                end else begin
                    sclk_sy[i] <= sclk_sy[(i == 0) ? 0 : i - 1];
                    cs_sy[i]   <= cs_sy[(i == 0) ? 0 : i - 1];
                    mosi_sy[i] <= mosi_sy[(i == 0) ? 0 : i - 1];
                end
            end
        end
    endgenerate

    assign sclk_s = sclk_sy[TOP];
    assign cs_s   = cs_sy[TOP];
    assign mosi_s = mosi_sy[TOP];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_d <= 1'b0;
            cs_d   <= 1'b1;
        end else begin
            sclk_d <= sclk_s;
            cs_d   <= cs_s;
        end
    end

    assign sclk_rise = sclk_s & ~sclk_d;
    assign sclk_fall = ~sclk_s & sclk_d;
    assign cs_act    = ~cs_s;
    assign cs_fall   = ~cs_s & cs_d;
    assign cs_rise   = cs_s & ~cs_d;
    assign byte_done = cs_act & sclk_rise & (bit_cnt == 3'd7);
    assign rx_byte   = {rx_sr, mosi_s};
    assign miso      = tx_sr[7];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            rx_sr   <= '0;
            tx_sr   <= '0;
        end else if (!cs_act) begin
            bit_cnt <= '0;
            tx_sr   <= '0;
        end else begin
            if (sclk_rise) begin
                rx_sr   <= {rx_sr[5:0], mosi_s};
                bit_cnt <= bit_cnt + 3'd1;
            end
            if (tx_load) begin
                tx_sr <= tx_byte;
            end else if (sclk_fall && bit_cnt != 3'd0) begin
                tx_sr <= {tx_sr[6:0], 1'b0};
            end
        end
    end
endmodule

// File: rtl/ready_pulse_gen.sv
module ready_pulse_gen #(
    parameter int SHORT_CYC = 1000,
    parameter int LONG_CYC  = 25000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic long_mode,
    output logic pulse_n
);
    localparam int CNT_W = $clog2(LONG_CYC + 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= long_mode ? CNT_W'(LONG_CYC) : CNT_W'(SHORT_CYC);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign pulse_n = (cnt_q == '0);
endmodule

// File: rtl/tpm_spi_target.sv
module tpm_spi_target
    import tpm_spi_pkg::*;
#(
    parameter int          ADDR_W    = 24,
    parameter int          LEN_W     = 6,
    parameter int          SHORT_CYC = 1000,
    parameter int          LONG_CYC  = 25000,
    parameter logic [11:0] CFG_ADDR  = 12'hFE0,
    parameter int          CFG_BIT   = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sclk,
    input  logic              spi_cs_n,
    input  logic              spi_mosi,
    output logic              spi_miso,
    output logic              irq_rdy_n,
    input  logic              reg_ready,
    output logic              reg_rd,
    output logic              reg_wr,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [7:0]        reg_wdata,
    input  logic [7:0]        reg_rdata
);
    localparam int IDX_W = $clog2(HDR_BYTES);
    localparam logic [IDX_W-1:0] LAST_HDR = IDX_W'(HDR_BYTES - 1);

    tgt_state_e        state_q, state_d;
    logic [IDX_W-1:0]  hdr_idx_q;
    logic              is_read_q;
    logic [LEN_W-1:0]  len_m1_q;
    logic [LEN_W-1:0]  dcnt_q;
    logic [ADDR_W-1:0] addr_q;
    logic              long_mode_q;

    logic       cs_act, cs_fall, cs_rise, byte_done;
    logic [7:0] rx_byte;
    logic       tx_load;
    logic [7:0] tx_byte;
    logic       last_byte, hdr_end, pulse_start, cfg_hit;

    spi_byte_port #(.SYNC_STAGES(2)) u_port (
        .clk      (clk),
        .rst_n    (rst_n),
        .sclk     (spi_sclk),
        .cs_n     (spi_cs_n),
        .mosi     (spi_mosi),
        .tx_load  (tx_load),
        .tx_byte  (tx_byte),
        .miso     (spi_miso),
        .cs_act   (cs_act),
        .cs_fall  (cs_fall),
        .cs_rise  (cs_rise),
        .byte_done(byte_done),
        .rx_byte  (rx_byte)
    );

    ready_pulse_gen #(.SHORT_CYC(SHORT_CYC), .LONG_CYC(LONG_CYC)) u_pulse (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (pulse_start),
        .long_mode(long_mode_q),
        .pulse_n  (irq_rdy_n)
    );

    assign last_byte   = (dcnt_q == len_m1_q);
    assign hdr_end     = byte_done && (hdr_idx_q == LAST_HDR);
    assign pulse_start = cs_rise && (state_q == ST_DONE);
    assign cfg_hit     = reg_wr && (addr_q[11:0] == CFG_ADDR);
    assign reg_addr    = addr_q;
    assign reg_wdata   = rx_byte;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (cs_fall) state_d = ST_HDR;
            ST_HDR:  if (hdr_end) state_d = reg_ready ? ST_RDY : ST_WAIT;
            ST_WAIT: if (byte_done && reg_ready) state_d = ST_RDY;
            ST_RDY:  if (byte_done) state_d = ST_DATA;
            ST_DATA: if (byte_done && last_byte) state_d = ST_DONE;
            ST_DONE: state_d = ST_DONE;
            default: state_d = ST_IDLE;
        endcase
        if (cs_rise) state_d = ST_IDLE;
    end

    // Output logic: next MISO byte and register strobes
    always_comb begin
        tx_load = 1'b0;
        tx_byte = WAIT_BYTE;
        reg_rd  = 1'b0;
        reg_wr  = 1'b0;
        unique case (state_q)
            ST_HDR: begin
                if (hdr_end) begin
                    tx_load = 1'b1;
                    tx_byte = reg_ready ? GO_BYTE : WAIT_BYTE;
                end
            end
            ST_WAIT: begin
                if (byte_done) begin
                    tx_load = 1'b1;
                    tx_byte = reg_ready ? GO_BYTE : WAIT_BYTE;
                end
            end
            ST_RDY: begin
                if (byte_done) begin
                    tx_load = 1'b1;
                    if (is_read_q) begin
                        reg_rd  = 1'b1;
                        tx_byte = reg_rdata;
                    end
                end
            end
            ST_DATA: begin
                if (byte_done) begin
                    tx_load = 1'b1;
                    if (!is_read_q) begin
                        reg_wr = 1'b1;
                    end else if (!last_byte) begin
                        reg_rd  = 1'b1;
                        tx_byte = reg_rdata;
                    end
                end
            end
            default: begin
                tx_load = 1'b0;
            end
        endcase
    end

    // Header, address and payload counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hdr_idx_q   <= '0;
            is_read_q   <= 1'b0;
            len_m1_q    <= '0;
            dcnt_q      <= '0;
            addr_q      <= '0;
            long_mode_q <= 1'b0;
        end else begin
            if (state_q == ST_IDLE) begin
                hdr_idx_q <= '0;
                dcnt_q    <= '0;
            end
            if (state_q == ST_HDR && byte_done) begin
                hdr_idx_q <= hdr_idx_q + 1'b1;
                if (hdr_idx_q == '0) begin
                    is_read_q <= rx_byte[7];
                    len_m1_q  <= rx_byte[LEN_W-1:0];
                end else begin
                    addr_q <= {addr_q[ADDR_W-9:0], rx_byte};
                end
            end
            if (reg_rd || reg_wr) begin
                addr_q <= addr_q + 1'b1;
            end
            if (state_q == ST_DATA && byte_done) begin
                dcnt_q <= dcnt_q + 1'b1;
            end
            if (cfg_hit) begin
                long_mode_q <= rx_byte[CFG_BIT];
            end
        end
    end
endmodule

// File: rtl/tpm_spi_target_chk.sv
module tpm_spi_target_chk
    import tpm_spi_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input tgt_state_e state_q,
    input logic       byte_done,
    input logic       cs_rise,
    input logic       pulse_start,
    input logic       is_read_q,
    input logic       reg_ready,
    input logic       reg_rd,
    input logic       reg_wr,
    input logic       irq_rdy_n
);
    // R3: without readiness the target keeps stalling
    a_r3_stall_held: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_done && state_q == ST_WAIT && !reg_ready) |=> state_q == ST_WAIT);

    // R5 / R6: never both strobes at once, writes only on write transactions
    a_r5_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_rd && reg_wr));
    a_r6_wr_only_write: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |-> !is_read_q);

    // R7: pulse begins right after a completed transaction ends
    a_r7_pulse_starts: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_start |=> !irq_rdy_n);
    a_r7_pulse_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_rdy_n) |-> $past(pulse_start));

    // R9: chip-select release always returns to idle
    a_r9_abort_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        cs_rise |=> state_q == ST_IDLE);

    // R10: no access after the payload
    a_r10_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DONE) |-> (!reg_rd && !reg_wr));
endmodule

bind tpm_spi_target tpm_spi_target_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .state_q    (state_q),
    .byte_done  (byte_done),
    .cs_rise    (cs_rise),
    .pulse_start(pulse_start),
    .is_read_q  (is_read_q),
    .reg_ready  (reg_ready),
    .reg_rd     (reg_rd),
    .reg_wr     (reg_wr),
    .irq_rdy_n  (irq_rdy_n)
);

// File: tb/tpm_spi_target_tb.sv
module tpm_spi_target_tb;
    localparam int SHORT = 1000;
    localparam int LONG  = 25000;
    localparam int H     = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        spi_sclk = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0;
    logic        spi_miso, irq_rdy_n;
    logic        reg_ready = 1'b0;
    logic        reg_rd, reg_wr;
    logic [23:0] reg_addr;
    logic [7:0]  reg_wdata, reg_rdata;

    int tests = 0, fails = 0;
    int lowc = 0, last_len = 0, pulses = 0;
    logic [23:0] rd_q[$];
    logic [31:0] wr_q[$];
    logic [7:0]  wbuf[64];

    always #2 clk = ~clk;

    function automatic logic [7:0] rfn(input logic [23:0] a);
        return (a[7:0] + 8'h3C) ^ a[15:8];
    endfunction

    assign reg_rdata = rfn(reg_addr);

    tpm_spi_target u_dut (
        .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .irq_rdy_n(irq_rdy_n),
        .reg_ready(reg_ready), .reg_rd(reg_rd), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    // Monitors, sampled away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (reg_rd) rd_q.push_back(reg_addr);
            if (reg_wr) wr_q.push_back({reg_addr, reg_wdata});
            if (!irq_rdy_n) lowc++;
            else if (lowc != 0) begin
                last_len = lowc;
                pulses++;
                lowc = 0;
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx);
        for (int b = 7; b >= 0; b--) begin
            spi_mosi = tx[b];
            repeat (H) @(negedge clk);
            spi_sclk = 1'b1;
            rx[b] = spi_miso;
            repeat (H) @(negedge clk);
            spi_sclk = 1'b0;
        end
    endtask

    task automatic wait_pulse(input int p0);
        for (int i = 0; i < LONG + 300 && pulses == p0; i++) @(negedge clk);
    endtask

    task automatic txn(input bit rd, input int len, input logic [23:0] addr,
                       input int waits, input int extra, input bit exp_long);
        logic [7:0] rx;
        logic [7:0] hdr [3];
        int ws;
        bit got;
        int p0;
        p0 = pulses;
        rd_q.delete();
        wr_q.delete();
        reg_ready = 1'b0;
        @(negedge clk);
        spi_cs_n = 1'b0;
        repeat (H) @(negedge clk);
        hdr[0] = {rd, 1'b0, 6'(len - 1)};
        hdr[1] = addr[23:16];
        hdr[2] = addr[15:8];
        for (int i = 0; i < 3; i++) begin
            xbyte(hdr[i], rx);
            chk("R3 header byte", {24'h0, rx}, 32'h0);
        end
        ws = 0;
        got = 1'b0;
        for (int k = 0; k < 40 && !got; k++) begin
            if (k == waits) reg_ready = 1'b1;
            xbyte((k == 0) ? addr[7:0] : 8'h00, rx);
            if (k == 0) chk("R3 header byte", {24'h0, rx}, 32'h0);
            else if (rx[0]) begin
                got = 1'b1;
                chk("R4 ready byte", {24'h0, rx}, 32'h01);
            end else begin
                ws++;
                chk("R3 wait byte", {24'h0, rx}, 32'h0);
            end
        end
        chk("R3 wait count", ws, waits);
        for (int i = 0; i < len; i++) begin
            xbyte(rd ? 8'h00 : wbuf[i], rx);
            if (rd) chk("R5 read data", {24'h0, rx}, {24'h0, rfn(addr + 24'(i))});
            else    chk("R6 miso in write", {24'h0, rx}, 32'h0);
        end
        for (int i = 0; i < extra; i++) begin
            xbyte(8'hA5, rx);
            chk("R10 trailing byte", {24'h0, rx}, 32'h0);
        end
        repeat (H) @(negedge clk);
        spi_cs_n = 1'b1;
        reg_ready = 1'b0;
        wait_pulse(p0);
        chk("R7 pulse count", pulses, p0 + 1);
        chk(exp_long ? "R8 long pulse" : "R7 short pulse", last_len, exp_long ? LONG : SHORT);
        if (rd) begin
            chk("R5 read strobes", rd_q.size(), len);
            chk("R10 no write strobes", wr_q.size(), 0);
            for (int i = 0; i < len && i < rd_q.size(); i++)
                chk("R5 read addr", {8'h0, rd_q[i]}, {8'h0, addr + 24'(i)});
        end else begin
            chk("R6 write strobes", wr_q.size(), len);
            chk("R10 no read strobes", rd_q.size(), 0);
            for (int i = 0; i < len && i < wr_q.size(); i++)
                chk("R6 write addr/data", wr_q[i], {addr + 24'(i), wbuf[i]});
        end
        repeat (20) @(negedge clk);
    endtask

    task automatic abort_txn();
        logic [7:0] rx;
        int p0;
        p0 = pulses;
        rd_q.delete();
        wr_q.delete();
        reg_ready = 1'b1;
        @(negedge clk);
        spi_cs_n = 1'b0;
        repeat (H) @(negedge clk);
        xbyte(8'h83, rx);
        xbyte(8'hD4, rx);
        repeat (H) @(negedge clk);
        spi_cs_n = 1'b1;
        repeat (SHORT + 200) @(negedge clk);
        reg_ready = 1'b0;
        chk("R9 no pulse on abort", pulses, p0);
        chk("R9 no strobes on abort", rd_q.size() + wr_q.size(), 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk("R1 rdy_n reset", irq_rdy_n, 1);
        chk("R1 miso reset", spi_miso, 0);
        chk("R1 strobes reset", {reg_rd, reg_wr}, 0);

        wbuf[0] = 8'hDE; wbuf[1] = 8'hAD; wbuf[2] = 8'hBE; wbuf[3] = 8'hEF;
        txn(1'b0, 4, 24'hD40024, 0, 0, 1'b0);       // R2 R6 write, no stall
        txn(1'b1, 4, 24'hD40F00, 3, 0, 1'b0);       // R2 R5 read, three wait bytes
        wbuf[0] = 8'h02;
        txn(1'b0, 1, 24'hD40FE4, 1, 0, 1'b0);       // R8 other address: no mode change
        txn(1'b0, 1, 24'hD40FE0, 1, 0, 1'b1);       // R8 set long mode
        txn(1'b1, 2, 24'hD400F0, 2, 0, 1'b1);       // R8 long pulse persists
        wbuf[0] = 8'hFD;
        txn(1'b0, 1, 24'hD40FE0, 0, 0, 1'b0);       // R8 clear long mode
        abort_txn();                                // R9 abort mid header
        txn(1'b1, 1, 24'h000123, 0, 2, 1'b0);       // R9 fresh header, R10 trailing bytes
        for (int i = 0; i < 8; i++) wbuf[i] = 8'(8'h11 * (i + 1));
        txn(1'b0, 8, 24'hD40FFC, 5, 1, 1'b0);       // R6 longer write, R10

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule